// File: doc/BRIEF.md
# HDLC Frame Receiver

This block takes a serial line, one bit per cycle in which a bit strobe is high, and turns it into checked HDLC frames. It hunts for the flag pattern at every bit position, strips the zeros that the sender inserts after five ones, and spots aborts. It runs the reflected CCITT CRC over everything between the flags, and it drops frames whose leading address bytes match neither the programmed address nor the all-call address.

Accepted frames leave as a byte stream. The first byte carries a start marker. Each frame ends with a single end pulse that carries a status code. The two check bytes never appear on the byte stream. Instead, they are latched on a separate 16-bit output. The output is held back by two bytes, so the check bytes can be dropped without knowing in advance where the frame ends.

Top module: `hdlc_rx`

## Requirements
- R1: After reset the receiver ignores all bits until it sees a flag (0, six 1s, 0) at any bit offset, and all outputs are zero.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed before bytes are assembled. Bytes are assembled LSB first.
- R3: The CRC (polynomial x^16+x^12+x^5+1, reflected, preset all ones) covers the address, the data and the received check bytes. The end status is GOOD (0) only if the result is 0xF0B8, and BAD_FCS (1) otherwise.
- R4: A frame with fewer than 32 bits between its flags ends with status SHORT (2).
- R5: The address and data bytes appear on rx_data with rx_valid, in order. rx_sof is high with the first byte. The two check bytes are never output.
- R6: When cfg_two_byte is 0, the first byte must equal cfg_addr_a. When it is 1, the first two bytes must equal cfg_addr_a and then cfg_addr_b. A frame that fails this produces no byte and no end pulse.
- R7: An address of 0xFF in every address byte is accepted whatever cfg_addr_a and cfg_addr_b hold.
- R8: At the end of a GOOD or BAD_FCS frame, rx_fcs loads {second check byte, first check byte}. At all other times rx_fcs holds its value.
- R9: Seven 1s in a row inside a frame end the frame with status ABORT (3). The receiver then hunts for a new flag, and bits before that flag produce nothing.
- R10: A closing flag that follows a bit count that is not a multiple of 8 ends the frame with status MISALIGN (4).
- R11: rx_eof is a one-cycle pulse that never coincides with rx_valid. Cycles with bit_en low have no effect.
- R12: Flags with no data between them produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | Bit strobe; bit_in is taken when high |
| bit_in | input | 1 | Serial line bit |
| cfg_two_byte | input | 1 | 1 selects a two-byte address |
| cfg_addr_a | input | 8 | Expected first address byte |
| cfg_addr_b | input | 8 | Expected second address byte |
| rx_valid | output | 1 | Byte strobe |
| rx_data | output | 8 | Received byte |
| rx_sof | output | 1 | First byte of a frame |
| rx_eof | output | 1 | End-of-frame pulse |
| rx_status | output | 3 | Frame status, valid with rx_eof |
| rx_fcs | output | 16 | Last received check bytes |

## Verification
A byte is released by the strobed bit that completes the byte two places behind it. That bit reaches the byte stage only after seven further data bits, because of the flag hold-back. rx_valid then rises one cycle after that strobe's edge. rx_eof and rx_fcs change one cycle after the edge of the closing flag's last 0, or after the seventh 1 of an abort. The bench drives inputs just after the rising edge and records every output pulse on the falling edge. Each frame's results are compared only after three idle cycles following its last bit, so no due cycle is missed. The frame table is run a second time with an idle cycle between bits, which shows that strobe gaps shift the results but do not change them.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   typedef enum logic [2:0] {
      RX_GOOD     = 3'd0,
      RX_BAD_FCS  = 3'd1,
      RX_SHORT    = 3'd2,
      RX_ABORT    = 3'd3,
      RX_MISALIGN = 3'd4
   } rx_status_e;
endpackage

// File: rtl/hdlc_rx_deframe.sv
// Flag hunt, abort detection, zero removal and a hold-back that hides the flag prefix.
module hdlc_rx_deframe #(
   parameter int FLAG_ONES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output logic dat_valid,
   output logic dat_bit,
   output logic close_evt,
   output logic abort_evt
);
   localparam int HOLD_BITS = FLAG_ONES + 1;
   localparam int CW        = $clog2(HOLD_BITS + 1);

   logic [CW-1:0]        ones_q;
   logic [CW-1:0]        pcnt_q;
   logic [HOLD_BITS-1:0] pend_q;
   logic                 hunt_q;
   logic                 at_flag, at_abort, at_stuff, is_data;

   always_comb begin
      at_flag   = bit_en && !bit_in && (ones_q == CW'(FLAG_ONES));
      at_abort  = bit_en &&  bit_in && (ones_q == CW'(FLAG_ONES));
      at_stuff  = bit_en && !bit_in && (ones_q == CW'(FLAG_ONES - 1));
      is_data   = bit_en && !hunt_q && !at_flag && !at_abort && !at_stuff;
      dat_valid = is_data && (pcnt_q == CW'(HOLD_BITS));
      dat_bit   = pend_q[0];
      close_evt = at_flag && !hunt_q;
      abort_evt = at_abort && !hunt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
         pcnt_q <= '0;
         pend_q <= '0;
         hunt_q <= 1'b1;
      end else if (bit_en) begin
         if (bit_in) begin
            if (ones_q != CW'(HOLD_BITS)) ones_q <= ones_q + 1'b1;
         end else begin
            ones_q <= '0;
         end
         if (at_flag) begin
            hunt_q <= 1'b0;
            pcnt_q <= '0;
         end else if (at_abort) begin
            hunt_q <= 1'b1;
            pcnt_q <= '0;
         end else if (is_data) begin
            pend_q <= {bit_in, pend_q[HOLD_BITS-1:1]};
            if (pcnt_q != CW'(HOLD_BITS)) pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_crc.sv
// Bit-serial reflected CRC register.
module hdlc_rx_crc #(
   parameter int             W      = 16,
   parameter logic [W-1:0]   POLY_R = 16'h8408,
   parameter logic [W-1:0]   INIT   = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         step,
   input  logic         bit_in,
   output logic [W-1:0] crc
);
   logic [W-1:0] nxt;

   always_comb nxt = {1'b0, crc[W-1:1]} ^ ((crc[0] ^ bit_in) ? POLY_R : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc <= INIT;
      else if (clear) crc <= INIT;
      else if (step)  crc <= nxt;
   end
endmodule

// File: rtl/hdlc_rx_framer.sv
// Byte assembly, address filter, two-byte hold-back and end-of-frame status.
module hdlc_rx_framer
   import hdlc_rx_pkg::*;
#(
   parameter int          MIN_BYTES = 4,
   parameter logic [7:0]  ALL_CALL  = 8'hFF,
   parameter logic [15:0] RESIDUE   = 16'hF0B8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dat_valid,
   input  logic        dat_bit,
   input  logic        close_evt,
   input  logic        abort_evt,
   input  logic [15:0] crc,
   input  logic        cfg_two_byte,
   input  logic [7:0]  cfg_addr_a,
   input  logic [7:0]  cfg_addr_b,
   output logic        rx_valid,
   output logic [7:0]  rx_data,
   output logic        rx_sof,
   output logic        rx_eof,
   output logic [2:0]  rx_status,
   output logic [15:0] rx_fcs
);
   localparam int NB_W = $clog2(MIN_BYTES + 1);

   logic [2:0]      bcnt_q;
   logic [7:0]      sh_q, hold0_q, hold1_q, new_byte;
   logic [NB_W-1:0] nb_q;
   logic            busy_q, drop_q, m_exact_q, m_all_q, addr_b_ok;
   rx_status_e      st_next;

   always_comb begin
      new_byte  = {dat_bit, sh_q[7:1]};
      addr_b_ok = (m_exact_q && new_byte == cfg_addr_b) ||
                  (m_all_q && new_byte == ALL_CALL);
      if (abort_evt)                      st_next = RX_ABORT;
      else if (bcnt_q != 3'd0)            st_next = RX_MISALIGN;
      else if (nb_q < NB_W'(MIN_BYTES))   st_next = RX_SHORT;
      else if (crc != RESIDUE)            st_next = RX_BAD_FCS;
      else                                st_next = RX_GOOD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0; sh_q <= '0; hold0_q <= '0; hold1_q <= '0; nb_q <= '0;
         busy_q <= 1'b0; drop_q <= 1'b0; m_exact_q <= 1'b0; m_all_q <= 1'b0;
         rx_valid <= 1'b0; rx_data <= '0; rx_sof <= 1'b0; rx_eof <= 1'b0;
         rx_status <= '0; rx_fcs <= '0;
      end else begin
         rx_valid <= 1'b0;
         rx_sof   <= 1'b0;
         rx_eof   <= 1'b0;
         if (close_evt || abort_evt) begin
            if (busy_q && !drop_q) begin
               rx_eof    <= 1'b1;
               rx_status <= st_next;
               if (st_next == RX_GOOD || st_next == RX_BAD_FCS)
                  rx_fcs <= {hold1_q, hold0_q};
            end
            bcnt_q <= '0; nb_q <= '0; busy_q <= 1'b0; drop_q <= 1'b0;
            m_exact_q <= 1'b0; m_all_q <= 1'b0;
         end else if (dat_valid) begin
            busy_q <= 1'b1;
            sh_q   <= new_byte;
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) begin
               hold1_q <= new_byte;
               hold0_q <= hold1_q;
               if (nb_q != NB_W'(MIN_BYTES)) nb_q <= nb_q + 1'b1;
               if (nb_q == '0) begin
                  m_exact_q <= (new_byte == cfg_addr_a);
                  m_all_q   <= (new_byte == ALL_CALL);
                  if (!cfg_two_byte && new_byte != cfg_addr_a && new_byte != ALL_CALL)
                     drop_q <= 1'b1;
               end
               if (nb_q == NB_W'(1) && cfg_two_byte && !addr_b_ok)
                  drop_q <= 1'b1;
               if (nb_q >= NB_W'(2) && !drop_q) begin
                  rx_valid <= 1'b1;
                  rx_data  <= hold0_q;
                  rx_sof   <= (nb_q == NB_W'(2));
               end
            end
         end
      end
   end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx #(
   parameter int          FLAG_ONES = 6,
   parameter int          MIN_BYTES = 4,
   parameter logic [7:0]  ALL_CALL  = 8'hFF,
   parameter logic [15:0] RESIDUE   = 16'hF0B8,
   parameter logic [15:0] POLY_R    = 16'h8408
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bit_en,
   input  logic        bit_in,
   input  logic        cfg_two_byte,
   input  logic [7:0]  cfg_addr_a,
   input  logic [7:0]  cfg_addr_b,
   output logic        rx_valid,
   output logic [7:0]  rx_data,
   output logic        rx_sof,
   output logic        rx_eof,
   output logic [2:0]  rx_status,
   output logic [15:0] rx_fcs
);
   generate
      if (MIN_BYTES < 3) begin : g_bad_min
         $error("MIN_BYTES must cover the address byte and both check bytes");
      end
      if (FLAG_ONES < 2) begin : g_bad_flag
         $error("FLAG_ONES must be at least 2");
      end
   endgenerate

   logic        dat_valid, dat_bit, close_evt, abort_evt;
   logic [15:0] crc;

   hdlc_rx_deframe #(.FLAG_ONES(FLAG_ONES)) i_deframe (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .dat_valid(dat_valid), .dat_bit(dat_bit),
      .close_evt(close_evt), .abort_evt(abort_evt));

   hdlc_rx_crc #(.W(16), .POLY_R(POLY_R), .INIT(16'hFFFF)) i_crc (
      .clk(clk), .rst_n(rst_n), .clear(close_evt || abort_evt),
      .step(dat_valid), .bit_in(dat_bit), .crc(crc));

   hdlc_rx_framer #(.MIN_BYTES(MIN_BYTES), .ALL_CALL(ALL_CALL), .RESIDUE(RESIDUE)) i_framer (
      .clk(clk), .rst_n(rst_n), .dat_valid(dat_valid), .dat_bit(dat_bit),
      .close_evt(close_evt), .abort_evt(abort_evt), .crc(crc),
      .cfg_two_byte(cfg_two_byte), .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_status(rx_status), .rx_fcs(rx_fcs));
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bit_en,
   input logic        rx_valid,
   input logic        rx_sof,
   input logic        rx_eof,
   input logic [2:0]  rx_status,
   input logic [15:0] rx_fcs
);
   // R5: a start marker only rides on a byte
   p_sof_on_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_sof |-> rx_valid);

   // R11: byte strobe and end pulse never together
   p_one_marker_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid, rx_eof}));

   // R11: nothing comes out unless the previous cycle carried a bit
   p_needs_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_en) |-> (!rx_valid && !rx_eof));

   // R8: check bytes move only at the end of a checked frame
   p_fcs_at_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_fcs) |-> (rx_eof && rx_status <= 3'd1));

   // R10: status codes stay in the defined set
   p_status_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eof |-> (rx_status <= 3'd4));
endmodule

bind hdlc_rx hdlc_rx_chk i_hdlc_rx_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_valid(rx_valid),
   .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_status(rx_status), .rx_fcs(rx_fcs));

// File: tb/test_hdlc_rx.sv
module test_hdlc_rx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0, bit_in = 1'b0, cfg_two_byte = 1'b0;
   logic [7:0]  cfg_addr_a = 8'h5A, cfg_addr_b = 8'hC3;
   logic        rx_valid, rx_sof, rx_eof;
   logic [7:0]  rx_data;
   logic [2:0]  rx_status;
   logic [15:0] rx_fcs;

   int n_run = 0, n_fail = 0, gap = 0, ones = 0;
   int tot_cap = 0, tot_eof = 0, tot_sof = 0, sof_at = 0;
   logic [7:0] cap [256];
   logic [2:0] last_st = 3'd0;

   always #2 clk = ~clk;

   hdlc_rx i_hdlc_rx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .cfg_two_byte(cfg_two_byte), .cfg_addr_a(cfg_addr_a), .cfg_addr_b(cfg_addr_b),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_status(rx_status), .rx_fcs(rx_fcs));

   // monitor: every output pulse is recorded on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            cap[tot_cap % 256] = rx_data;
            if (rx_sof) begin tot_sof = tot_sof + 1; sof_at = tot_cap; end
            tot_cap = tot_cap + 1;
         end
         if (rx_eof) begin tot_eof = tot_eof + 1; last_st = rx_status; end
      end
   end

   // {two_byte, exp_status(7 = dropped), corrupt, len, 8'h0, bytes b5..b0}
   localparam int NV = 10;
   localparam logic [63:0] VEC [NV] = '{
      64'h0300_0000_0002_015A,   // plain one-byte address
      64'h0300_0000_00FF_7EFF,   // all-call, flag and ones in data
      64'h7200_0000_0000_1133,   // wrong address
      64'h1C00_0000_3020_105A,   // corrupted payload
      64'h8300_0000_0044_C35A,   // two-byte address
      64'h8300_0000_0009_FFFF,   // two-byte all-call
      64'hF300_0000_0055_C45A,   // second byte wrong
      64'hF300_0000_0055_C3FF,   // half all-call
      64'h0400_0000_3EF8_1F5A,   // heavy zero insertion
      64'h2100_0000_0000_005A    // 24 bits only
   };

   function automatic string tag_of(input int v);
      case (v)
         1, 8:    return "R2";
         3:       return "R3";
         2, 4, 6: return "R6";
         5, 7:    return "R7";
         9:       return "R4";
         default: return "R5";
      endcase
   endfunction

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
         else             r = r >> 1;
      end
      return r;
   endfunction

   task automatic check(input logic ok, input string tag, input string what,
                        input int act, input int exp);
      n_run = n_run + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic send_raw(input logic b);
      bit_en = 1'b1; bit_in = b;
      @(posedge clk); #1;
      bit_en = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic send_flag();
      send_raw(1'b0);
      repeat (6) send_raw(1'b1);
      send_raw(1'b0);
      ones = 0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         send_raw(b[i]);
         if (b[i]) ones = ones + 1; else ones = 0;
         if (ones == 5) begin send_raw(1'b0); ones = 0; end
      end
   endtask

   // sends payload and check bytes; returns transmitted check value
   task automatic send_body(input logic [7:0] pl [6], input int len, input logic corrupt,
                            output logic [15:0] fcs);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < len; i++) c = crc_byte(c, pl[i]);
      fcs = ~c;
      for (int i = 0; i < len; i++)
         send_byte((corrupt && i == len - 1) ? (pl[i] ^ 8'h01) : pl[i]);
      send_byte(fcs[7:0]);
      send_byte(fcs[15:8]);
   endtask

   task automatic run_vec(input int v);
      logic [63:0] vec = VEC[v];
      logic [7:0]  pl [6];
      logic [15:0] fcs;
      int len = int'(vec[58:56]);
      int st  = int'(vec[62:60]);
      int bc, be, bs;
      string tg = tag_of(v);
      for (int i = 0; i < 6; i++) pl[i] = vec[8*i +: 8];
      if (vec[59]) pl[len-1] = pl[len-1] ^ 8'h01;   // what the receiver should see
      if (vec[59]) pl[len-1] = pl[len-1] ^ 8'h01;   // restored for check computation
      cfg_two_byte = vec[63];
      bc = tot_cap; be = tot_eof; bs = tot_sof;
      send_flag();
      send_body(pl, len, vec[59], fcs);
      send_flag();
      idle(3);
      if (vec[59]) pl[len-1] = pl[len-1] ^ 8'h01;
      if (st == 7) begin
         check(tot_cap == bc && tot_eof == be, tg, "filtered frame produced output",
               tot_cap - bc + tot_eof - be, 0);
      end else begin
         check(tot_eof - be == 1 && int'(last_st) == st, tg, "end status",
               int'(last_st), st);
         check(tot_cap - bc == len, "R5", "byte count", tot_cap - bc, len);
         for (int i = 0; i < len && i < tot_cap - bc; i++)
            check(cap[(bc + i) % 256] == pl[i], "R5", "byte value",
                  int'(cap[(bc + i) % 256]), int'(pl[i]));
         check(tot_sof - bs == 1 && sof_at == bc, "R5", "start marker position",
               sof_at - bc, 0);
         if (st == 0)
            check(rx_fcs == fcs, "R8", "check bytes output", int'(rx_fcs), int'(fcs));
      end
   endtask

   initial begin : watchdog
      #(4 * 200000);
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0]  pl [6];
      logic [15:0] fcs, keep;
      int bc, be;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check(!rx_valid && !rx_eof && rx_fcs == 16'h0 && rx_status == 3'd0, "R1",
            "reset state", int'(rx_fcs), 0);

      // R1: bits before any flag, including a full body, are ignored
      pl = '{8'h5A, 8'h21, 8'h43, 8'h00, 8'h00, 8'h00};
      bc = tot_cap; be = tot_eof;
      send_raw(1'b1); send_raw(1'b0); send_raw(1'b1); send_raw(1'b1);
      send_body(pl, 3, 1'b0, fcs);
      send_flag();
      idle(3);
      check(tot_cap == bc && tot_eof == be, "R1", "output before first flag",
            tot_cap - bc, 0);

      for (int p = 0; p < 2; p++) begin
         gap = p;   // second pass: idle cycle between bits (R11)
         for (int v = 0; v < NV; v++) run_vec(v);
      end
      gap = 0;
      cfg_two_byte = 1'b0;

      // R9: abort inside a frame
      pl = '{8'h5A, 8'h01, 8'h02, 8'h03, 8'h00, 8'h00};
      bc = tot_cap; be = tot_eof;
      send_flag();
      for (int i = 0; i < 4; i++) send_byte(pl[i]);
      repeat (7) send_raw(1'b1);
      idle(3);
      check(tot_eof - be == 1 && last_st == 3'd3, "R9", "abort status", int'(last_st), 3);
      check(tot_cap - bc == 1 && cap[bc % 256] == 8'h5A, "R9", "bytes before abort",
            tot_cap - bc, 1);
      // R9: after abort, a body with no opening flag is ignored
      bc = tot_cap; be = tot_eof;
      send_raw(1'b0);
      send_body(pl, 3, 1'b0, fcs);
      send_flag();
      idle(3);
      check(tot_cap == bc && tot_eof == be, "R9", "hunt after abort", tot_eof - be, 0);

      // R10: bit count not a byte multiple
      bc = tot_cap; be = tot_eof;
      send_flag();
      for (int i = 0; i < 4; i++) send_byte(pl[i]);
      send_raw(1'b0); send_raw(1'b0); send_raw(1'b1);
      send_flag();
      idle(3);
      check(tot_eof - be == 1 && last_st == 3'd4, "R10", "misaligned status",
            int'(last_st), 4);

      // R12: back-to-back flags, R8: fcs held
      keep = rx_fcs;
      bc = tot_cap; be = tot_eof;
      send_flag(); send_flag(); send_flag();
      idle(3);
      check(tot_cap == bc && tot_eof == be, "R12", "empty frames", tot_eof - be, 0);
      check(rx_fcs == keep, "R8", "check bytes held", int'(rx_fcs), int'(keep));

      // R11: long strobe-free stretch with line toggling changes nothing
      bc = tot_cap; be = tot_eof;
      for (int i = 0; i < 20; i++) begin bit_in = i[0]; idle(1); end
      check(tot_cap == bc && tot_eof == be, "R11", "no strobe no output", tot_cap - bc, 0);

      // R7: one-byte all-call after everything above
      pl = '{8'hFF, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00};
      bc = tot_cap; be = tot_eof;
      send_flag();
      send_body(pl, 2, 1'b0, fcs);
      send_flag();
      idle(3);
      check(tot_eof - be == 1 && last_st == 3'd0 && tot_cap - bc == 2, "R7",
            "all-call frame", int'(last_st), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule